// File: doc/BRIEF.md
# Timer Channel Clock Gate and Prescaler

This block controls the counting clocks of a ten-channel timer unit: eight general timers, an OS timer and a watchdog. Each channel selects one of three clock-enable pulse streams (peripheral, RTC or external) and divides it by a power of four. It gives a one-cycle tick enable each time the divided count wraps. Channels are gated on and off through one shared stop vector. That vector has separate write-one-to-set and write-one-to-clear locations and a read-only status view. All divided clocks are produced as enable strobes in the main clock domain, not as derived clocks.

Software reaches the block through a simple register bus: address, write strobe, write data and combinational read data. A channel's control register can be changed only while that channel is running. To change its source or rate, software ungates the channel, writes the control register and gates the channel again.

Top module: `tmr_clkgate`

## Requirements
- R1: After reset every implemented stop bit is 1, so status reads 0x0001_80FF. Every control register reads 0x04, which is the external source with prescale code 0.
- R2: A write to offset 0x00 sets each implemented stop bit whose data bit is 1 and leaves the others unchanged. Bits 0 to 7 belong to timers 0 to 7, bit 15 to the OS timer (channel index 8) and bit 16 to the watchdog (channel index 9).
- R3: A write to offset 0x04 clears each implemented stop bit whose data bit is 1 and leaves the others unchanged.
- R4: Offset 0x08 reads the stop vector, with unimplemented bits returning 0. Offsets 0x00, 0x04 and unmapped addresses read 0.
- R5: The control register of channel i sits at 0x10 + 4*i. Bits [2:0] hold a one-hot source select: bit 0 is the peripheral pulse, bit 1 the RTC pulse and bit 2 the external pulse. Bits [5:3] hold the prescale code n.
- R6: A write to a control register is accepted only while that channel's stop bit is 0. A write made while the channel is stopped leaves the register unchanged.
- R7: A running channel with a one-hot source advances a 10-bit counter on each pulse of the selected source. The tick output pulses for one cycle, in the cycle after the pulse that brings the low 2n counter bits to zero, so the tick rate is the source rate divided by 4^n. Codes 6 and 7 act as code 5 (divide by 1024).
- R8: A stopped channel produces no ticks, and its counter holds its value.
- R9: A channel whose source field is not one-hot produces no ticks.
- R10: An accepted write that changes a control register clears that channel's counter. A source pulse in the same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pclk_en | input | 1 | Peripheral clock-enable pulse |
| rtc_en | input | 1 | RTC clock-enable pulse |
| ext_en | input | 1 | External clock-enable pulse |
| tick | output | 10 | Per-channel tick enable; index 8 is the OS timer, index 9 the watchdog |

## Verification
The hardest cases to reach are the divide-by-1024 wrap and a counter reset that happens in the middle of a count. The first needs more than a thousand selected pulses while nothing else disturbs the channel. The second needs an accepted control write that arrives while pulses are flowing, which is possible only in a short window after the channel is ungated. The stimulus holds a channel at code 5, and then at code 7, under a steady external pulse train for over two thousand cycles. It then runs a long mixed phase in which clears, sets, control writes and random pulses interleave. In that phase rewrites land on running channels at arbitrary count values, and writes also land on stopped channels.

// File: rtl/tmr_clkgate_pkg.sv
package tmr_clkgate_pkg;
    localparam int NUM_TMR   = 8;
    localparam int NUM_CH    = NUM_TMR + 2;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 10;
    localparam int MAX_PS    = CNT_W / 2;
    localparam int OST_BIT   = 15;
    localparam int WDT_BIT   = 16;

    localparam logic [ADDR_W-1:0] A_SET    = 8'h00;
    localparam logic [ADDR_W-1:0] A_CLR    = 8'h04;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h08;
    localparam logic [ADDR_W-1:0] A_CTRL0  = 8'h10;

    typedef enum logic [2:0] {
        SRC_PCLK = 3'b001,
        SRC_RTC  = 3'b010,
        SRC_EXT  = 3'b100
    } src_e;

    typedef struct packed {
        logic [2:0] pscale;
        logic [2:0] src;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{pscale: 3'd0, src: SRC_EXT};

    function automatic int stop_idx(input int ch);
        if (ch < NUM_TMR)      return ch;
        else if (ch == NUM_TMR) return OST_BIT;
        else                    return WDT_BIT;
    endfunction

    function automatic logic [DATA_W-1:0] impl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = 0; c < NUM_CH; c++) m[stop_idx(c)] = 1'b1;
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] ctrl_addr(input int ch);
        return A_CTRL0 + ADDR_W'(4 * ch);
    endfunction

    function automatic logic src_valid(input logic [2:0] s);
        return (s == SRC_PCLK) || (s == SRC_RTC) || (s == SRC_EXT);
    endfunction

    function automatic logic [CNT_W-1:0] wrap_mask(input logic [2:0] ps);
        logic [CNT_W-1:0] m;
        int n;
        n = (int'(ps) > MAX_PS) ? MAX_PS : int'(ps);
        m = '0;
        for (int b = 0; b < CNT_W; b++) if (b < 2 * n) m[b] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/tmr_clkgate_stopreg.sv
module tmr_clkgate_stopreg
    import tmr_clkgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stop_q
);
    localparam logic [DATA_W-1:0] IMPL = impl_mask();

    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;

    assign set_bits = set_we ? (wdata & IMPL) : '0;
    assign clr_bits = clr_we ? (wdata & IMPL) : '0;

    always_ff @(posedge clk) begin
        if (rst) stop_q <= IMPL;
        else     stop_q <= (stop_q | set_bits) & ~clr_bits;
    end
endmodule

// File: rtl/tmr_clkgate_chan.sv
module tmr_clkgate_chan
    import tmr_clkgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       wr,
    input  ctrl_t      wr_val,
    input  logic [2:0] src_pulse,
    output ctrl_t      ctrl_o,
    output logic       tick_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             accept;
    logic             changed;
    logic             fire;

    assign accept  = wr && run;
    assign changed = accept && (wr_val != ctrl_q);
    assign fire    = run && src_valid(ctrl_q.src) && ((ctrl_q.src & src_pulse) != 3'b000);
    assign cnt_inc = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (changed) begin
                ctrl_q <= wr_val;
                cnt_q  <= '0;
            end else if (fire) begin
                cnt_q  <= cnt_inc;
                tick_o <= (cnt_inc & wrap_mask(ctrl_q.pscale)) == '0;
            end
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tmr_clkgate.sv
module tmr_clkgate
    import tmr_clkgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pclk_en,
    input  logic              rtc_en,
    input  logic              ext_en,
    output logic [NUM_CH-1:0] tick
);
    logic [DATA_W-1:0] stop_q;
    ctrl_t             ctrl_w [NUM_CH];
    logic [2:0]        pulses;

    assign pulses = {ext_en, rtc_en, pclk_en};

    tmr_clkgate_stopreg u_stop (
        .clk    (clk),
        .rst    (rst),
        .set_we (bus_we && bus_addr == A_SET),
        .clr_we (bus_we && bus_addr == A_CLR),
        .wdata  (bus_wdata),
        .stop_q (stop_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int SB = stop_idx(i);
        tmr_clkgate_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .run       (!stop_q[SB]),
            .wr        (bus_we && bus_addr == ctrl_addr(i)),
            .wr_val    (ctrl_t'(bus_wdata[5:0])),
            .src_pulse (pulses),
            .ctrl_o    (ctrl_w[i]),
            .tick_o    (tick[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STAT) bus_rdata = stop_q;
        for (int c = 0; c < NUM_CH; c++)
            if (bus_addr == ctrl_addr(c)) bus_rdata = {{(DATA_W-6){1'b0}}, ctrl_w[c]};
    end
endmodule

// File: rtl/tmr_clkgate_chk.sv
module tmr_clkgate_chk
    import tmr_clkgate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              pclk_en,
    input logic              rtc_en,
    input logic              ext_en,
    input logic [NUM_CH-1:0] tick,
    input logic [DATA_W-1:0] stop_q
);
    localparam logic [DATA_W-1:0] IMPL = impl_mask();

    a_r2_set_stops: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SET) |=>
        ((stop_q & $past(bus_wdata & IMPL)) == $past(bus_wdata & IMPL)));

    a_r3_clear_runs: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLR) |=> ((stop_q & $past(bus_wdata)) == '0));

    a_r4_status_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_STAT) |-> ((bus_rdata & ~IMPL) == '0));

    a_r7_no_pulse_no_tick: assert property (@(posedge clk) disable iff (rst)
        !$past(pclk_en || rtc_en || ext_en) |-> (tick == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        localparam int SB = stop_idx(i);
        a_r8_stopped_no_tick: assert property (@(posedge clk) disable iff (rst)
            $past(stop_q[SB]) |-> !tick[i]);
    end
endmodule

bind tmr_clkgate tmr_clkgate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pclk_en   (pclk_en),
    .rtc_en    (rtc_en),
    .ext_en    (ext_en),
    .tick      (tick),
    .stop_q    (stop_q)
);

// File: tb/tmr_clkgate_tb.sv
module tmr_clkgate_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pclk_en = 1'b0, rtc_en = 1'b0, ext_en = 1'b0;
    logic [9:0]  tick;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [31:0] m_stop;
    int m_src [10];
    int m_ps  [10];
    int m_cnt [10];
    logic [9:0] m_tick;

    always #10 clk = ~clk;

    tmr_clkgate u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pclk_en(pclk_en),
        .rtc_en(rtc_en), .ext_en(ext_en), .tick(tick)
    );

    function automatic int sbit(input int c);
        return (c < 8) ? c : ((c == 8) ? 15 : 16);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a == 8'h08) return m_stop;
        for (int c = 0; c < 10; c++)
            if (int'(a) == 16 + 4 * c) return 32'(m_ps[c] * 8 + m_src[c]);
        return 32'h0;
    endfunction

    task automatic model_reset();
        m_stop = 32'h0001_80FF;
        m_tick = '0;
        for (int c = 0; c < 10; c++) begin
            m_src[c] = 4; m_ps[c] = 0; m_cnt[c] = 0;
        end
    endtask

    task automatic model_step();
        logic [9:0] nt;
        nt = '0;
        for (int c = 0; c < 10; c++) begin
            bit run;
            bit sel;
            int n;
            run = !m_stop[sbit(c)];
            if (run && bus_we && int'(bus_addr) == 16 + 4 * c) begin
                int ns, np;
                ns = int'(bus_wdata[2:0]);
                np = int'(bus_wdata[5:3]);
                if (ns != m_src[c] || np != m_ps[c]) begin
                    m_src[c] = ns; m_ps[c] = np; m_cnt[c] = 0; // R10
                    continue;
                end
            end
            sel = (m_src[c] == 1 && pclk_en) || (m_src[c] == 2 && rtc_en) ||
                  (m_src[c] == 4 && ext_en);                    // R9: others never select
            if (run && sel) begin                               // R8: stopped holds
                m_cnt[c] = (m_cnt[c] + 1) % 1024;
                n = (m_ps[c] > 5) ? 5 : m_ps[c];
                if (m_cnt[c] % (1 << (2 * n)) == 0) nt[c] = 1'b1; // R7
            end
        end
        if (bus_we && bus_addr == 8'h00) m_stop = m_stop | (bus_wdata & 32'h0001_80FF); // R2
        if (bus_we && bus_addr == 8'h04) m_stop = m_stop & ~bus_wdata;                   // R3
        m_tick = nt;
    endtask

    task automatic cyc(input logic [7:0] a, input logic we, input logic [31:0] d,
                       input logic [2:0] p, input string tag);
        logic [31:0] er;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = d;
        {ext_en, rtc_en, pclk_en} = p;
        #1;
        er = exp_rd(a);
        checks++;
        if (bus_rdata !== er) begin
            fails++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, a, bus_rdata, er);
        end
        checks++;
        if (tick !== m_tick) begin
            fails++;
            $display("FAIL %s tick actual=%b expected=%b", tag, tick, m_tick);
        end
        model_step();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset values
        cyc(8'h08, 0, 0, 3'b000, "R1 status");
        for (int c = 0; c < 10; c++) cyc(8'(16 + 4 * c), 0, 0, 3'b000, "R1 ctrl");
        // R4 non-status reads give zero
        cyc(8'h00, 0, 0, 3'b000, "R4 set view");
        cyc(8'h04, 0, 0, 3'b000, "R4 clear view");
        cyc(8'h40, 0, 0, 3'b000, "R4 unmapped");
        // R6 write while stopped ignored
        cyc(8'h10, 1, 32'h11, 3'b111, "R6 stopped write");
        cyc(8'h10, 0, 0, 3'b111, "R6 readback");
        // R8 stopped channels: no ticks under pulses
        for (int k = 0; k < 20; k++) cyc(8'h08, 0, 0, 3'b111, "R8 stopped");
        // R3 clear with zero has no effect, then clear all
        cyc(8'h04, 1, 32'h0, 3'b000, "R3 zero");
        cyc(8'h08, 0, 0, 3'b000, "R3 status");
        cyc(8'h04, 1, 32'hFFFF_FFFF, 3'b000, "R3 all");
        cyc(8'h08, 0, 0, 3'b000, "R3 status");
        // R5 configure sources and prescales
        cyc(8'h10, 1, 32'(0*8 + 1), 3'b000, "R5 ch0");
        cyc(8'h14, 1, 32'(1*8 + 2), 3'b000, "R5 ch1");
        cyc(8'h18, 1, 32'(2*8 + 4), 3'b000, "R5 ch2");
        cyc(8'h1C, 1, 32'(5*8 + 4), 3'b000, "R5 ch3");
        cyc(8'h20, 1, 32'(7*8 + 4), 3'b000, "R5 ch4");
        cyc(8'h24, 1, 32'(0*8 + 3), 3'b000, "R9 ch5");
        cyc(8'h28, 1, 32'(0*8 + 0), 3'b000, "R9 ch6");
        cyc(8'h30, 1, 32'(1*8 + 1), 3'b000, "R5 ost");
        cyc(8'h34, 1, 32'(3*8 + 2), 3'b000, "R5 wdt");
        // R7 long runs: divide by 1024 via codes 5 and 7
        for (int k = 0; k < 2200; k++)
            cyc(8'(16 + 4 * (k % 10)), 0, 0, {1'b1, k[0], k[1]}, "R7 run");
        // R2 stop subset, then zero-bit set
        cyc(8'h00, 1, 32'h0001_0005, 3'b000, "R2 set");
        cyc(8'h00, 1, 32'h0, 3'b000, "R2 zero");
        cyc(8'h08, 0, 0, 3'b000, "R2 status");
        for (int k = 0; k < 40; k++) cyc(8'h08, 0, 0, 3'b111, "R8 partial stop");
        // R10 mid-count rewrite on running channel
        cyc(8'h14, 1, 32'(1*8 + 4), 3'b100, "R10 rewrite");
        for (int k = 0; k < 12; k++) cyc(8'h14, 0, 0, 3'b100, "R10 after");
        // mixed random phase
        for (int k = 0; k < 6000; k++) begin
            logic [7:0] a;
            logic [31:0] d;
            int r;
            r = $urandom % 8;
            case (r)
                0: begin a = 8'h00; d = $urandom & $urandom & $urandom; end
                1: begin a = 8'h04; d = $urandom | $urandom; end
                2: begin a = 8'h08; d = $urandom; end
                3: begin a = 8'h40; d = $urandom; end
                default: begin
                    a = 8'(16 + 4 * ($urandom % 10));
                    d = {26'($urandom), 3'($urandom % 3), 3'(1 << ($urandom % 3))};
                    if ($urandom % 8 == 0) d[2:0] = 3'($urandom);
                end
            endcase
            cyc(a, 1'($urandom % 3 == 0), d, 3'($urandom), "R7 mixed");
        end
        summary();
        $finish;
    end
endmodule